// File: doc/BRIEF.md
# BCD Clock and Calendar Counter

This block keeps the time of day and the calendar date in packed BCD. A single-cycle enable at twice the seconds rate drives it, and every second pulse advances the seconds field. Carries ripple through minutes and hours. On a change of day the day of month and the weekday both advance. The day of month then carries into the month, and the month carries into the two-digit year. When the year wraps, a century flag flips.

A host can load any field through a plain write port: field select, data and a write strobe. It reads any field back through a combinational select. A level-sensitive halt input freezes all counting. The first seconds step after the halt is released comes on the next enable, which is half a second later. A low-voltage flag sits in bit 7 of the seconds byte. Reset and a detect input set it. Any write to seconds clears it.

Top module: `bcd_calendar`

## Requirements
- R1: Seconds and minutes hold packed BCD values 00 to 59. Each wraps to 00 and carries one step into the next field. A units digit of 9 steps to the next tens digit with units 0.
- R2: Hours count 00 to 23. The wrap from 23 to 00 advances the day of month and the weekday by one.
- R3: The day of month returns to 01 and carries into the month after 31 in months 01, 03, 05, 07, 08, 10 and 12, and after 30 in months 04, 06, 09 and 11.
- R4: February ends after day 29 when the binary value of the two-digit year is a multiple of four (00 included), and after day 28 otherwise.
- R5: The month counts 01 to 12. The wrap from 12 to 01 advances the year, which counts 00 to 99.
- R6: The century flag is read as bit 7 of the month byte (field select 5). It inverts when the year wraps from 99 to 00. A month write loads it from data bit 7.
- R7: The weekday, a 3-bit field at select 4, counts 0 to 6 and wraps to 0.
- R8: While `halt` is 1, no field advances, whatever `tick` does.
- R9: After `halt` falls, the first `tick` gives a seconds step. After that, one step comes for every two ticks.
- R10: The low-voltage flag, bit 7 of the seconds byte (select 0), is 1 after reset and after `lv_detect`. Any seconds write clears it, whatever the data bit 7.
- R11: A host write to a field wins over a carry into that field in the same cycle. A seconds write restarts the sub-second phase, so the next step needs two ticks.
- R12: After reset the fields read: seconds 0x80, minutes 00, hours 00, day 01, weekday 0, month 01, year 00.

Field selects: 0 seconds, 1 minutes, 2 hours, 3 day of month, 4 weekday, 5 month, 6 year; select 7 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Single-cycle enable at twice the seconds rate |
| halt | input | 1 | Freezes counting while 1 |
| lv_detect | input | 1 | Sets the low-voltage flag |
| wr_en | input | 1 | Host write strobe |
| wr_sel | input | 3 | Field written |
| wr_data | input | 8 | Packed BCD write data |
| rd_sel | input | 3 | Field read |
| rd_data | output | 8 | Selected field, with flag bits in bit 7 |

## Verification
The range properties on seconds, hours, day and weekday take for granted that the host only ever loads legal BCD values. They also assume `tick` is high for one cycle at a time. A non-BCD load would make them fire even though the design behaves as specified. The stimulus loads only legal calendar values: every vector and directed write uses a real date and time. Ticks are always single-cycle pulses separated by idle cycles.

// File: rtl/rtcal_pkg.sv
package rtcal_pkg;

    localparam int NUM_FIELDS = 7;
    localparam int SEL_W      = 3;
    localparam int BYTE_W     = 8;

    typedef logic [BYTE_W-1:0] bcd8_t;

    typedef enum logic [SEL_W-1:0] {
        F_SEC   = 3'd0,
        F_MIN   = 3'd1,
        F_HOUR  = 3'd2,
        F_DAY   = 3'd3,
        F_WDAY  = 3'd4,
        F_MONTH = 3'd5,
        F_YEAR  = 3'd6
    } field_e;

    // next packed BCD value, no wrap handling
    function automatic bcd8_t bcd_inc(bcd8_t v);
        if (v[3:0] >= 4'd9)
            return {v[7:4] + 4'd1, 4'd0};
        else
            return {v[7:4], v[3:0] + 4'd1};
    endfunction

    function automatic int unsigned bcd_to_bin(bcd8_t v);
        return int'(v[7:4]) * 10 + int'(v[3:0]);
    endfunction

    function automatic logic is_leap(bcd8_t yr);
        return (bcd_to_bin(yr) % 4) == 0;
    endfunction

    function automatic bcd8_t month_days(bcd8_t mon, bcd8_t yr);
        case (mon)
            8'h02:                      return is_leap(yr) ? 8'h29 : 8'h28;
            8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
            default:                    return 8'h31;
        endcase
    endfunction

    // storage bits kept per field
    function automatic bcd8_t field_mask(int idx);
        case (idx)
            0, 1:    return 8'h7F;
            2, 3:    return 8'h3F;
            4:       return 8'h07;
            5:       return 8'h1F;
            default: return 8'hFF;
        endcase
    endfunction

    // last value before wrap (day of month is replaced at run time)
    function automatic bcd8_t field_top(int idx);
        case (idx)
            0, 1:    return 8'h59;
            2:       return 8'h23;
            3:       return 8'h31;
            4:       return 8'h06;
            5:       return 8'h12;
            default: return 8'h99;
        endcase
    endfunction

    // value after wrap, also the reset value
    function automatic bcd8_t field_low(int idx);
        return (idx == 3 || idx == 5) ? 8'h01 : 8'h00;
    endfunction

endpackage

// File: rtl/cal_tick_phase.sv
module cal_tick_phase (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic halt,
    input  logic resync,
    output logic sec_pulse
);
    logic phase;

    // phase = 1 means the next tick completes a second
    always_ff @(posedge clk) begin
        if (rst)
            phase <= 1'b0;
        else if (halt)
            phase <= 1'b1;
        else if (resync)
            phase <= 1'b0;
        else if (tick)
            phase <= ~phase;
    end

    assign sec_pulse = tick & ~halt & phase;
endmodule

// File: rtl/cal_lv_flag.sv
module cal_lv_flag (
    input  logic clk,
    input  logic rst,
    input  logic detect,
    input  logic clear,
    output logic flag
);
    always_ff @(posedge clk) begin
        if (rst)
            flag <= 1'b1;
        else if (detect)
            flag <= 1'b1;
        else if (clear)
            flag <= 1'b0;
    end
endmodule

// File: rtl/cal_field_ctr.sv
module cal_field_ctr
    import rtcal_pkg::*;
#(
    parameter bcd8_t LOW_VAL = 8'h00
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  inc,
    input  bcd8_t top,
    input  logic  wr,
    input  bcd8_t wr_val,
    output bcd8_t val,
    output logic  full
);
    assign full = (val == top);

    always_ff @(posedge clk) begin
        if (rst)
            val <= LOW_VAL;
        else if (wr)
            val <= wr_val;
        else if (inc)
            val <= full ? LOW_VAL : bcd_inc(val);
    end
endmodule

// File: rtl/bcd_calendar.sv
module bcd_calendar
    import rtcal_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             halt,
    input  logic             lv_detect,
    input  logic             wr_en,
    input  logic [SEL_W-1:0] wr_sel,
    input  logic [7:0]       wr_data,
    input  logic [SEL_W-1:0] rd_sel,
    output logic [7:0]       rd_data
);
    bcd8_t                 fval [NUM_FIELDS];
    bcd8_t                 ftop [NUM_FIELDS];
    logic [NUM_FIELDS-1:0] fwr;
    logic [NUM_FIELDS-1:0] finc;
    logic [NUM_FIELDS-1:0] full;
    logic                  sec_pulse;
    logic                  lv_flag;
    logic                  century;
    logic                  year_wrap;

    always_comb begin
        for (int i = 0; i < NUM_FIELDS; i++) begin
            fwr[i]  = wr_en && (wr_sel == SEL_W'(i));
            ftop[i] = field_top(i);
        end
        ftop[F_DAY] = month_days(fval[F_MONTH], fval[F_YEAR]);
    end

    cal_tick_phase u_phase (
        .clk       (clk),
        .rst       (rst),
        .tick      (tick),
        .halt      (halt),
        .resync    (fwr[F_SEC]),
        .sec_pulse (sec_pulse)
    );

    cal_lv_flag u_lv (
        .clk    (clk),
        .rst    (rst),
        .detect (lv_detect),
        .clear  (fwr[F_SEC]),
        .flag   (lv_flag)
    );

    // a written field passes no carry onward
    always_comb begin
        finc[F_SEC]   = sec_pulse;
        finc[F_MIN]   = finc[F_SEC]   & full[F_SEC]   & ~fwr[F_SEC];
        finc[F_HOUR]  = finc[F_MIN]   & full[F_MIN]   & ~fwr[F_MIN];
        finc[F_DAY]   = finc[F_HOUR]  & full[F_HOUR]  & ~fwr[F_HOUR];
        finc[F_WDAY]  = finc[F_DAY];
        finc[F_MONTH] = finc[F_DAY]   & full[F_DAY]   & ~fwr[F_DAY];
        finc[F_YEAR]  = finc[F_MONTH] & full[F_MONTH] & ~fwr[F_MONTH];
    end

    for (genvar i = 0; i < NUM_FIELDS; i++) begin : g_field
        cal_field_ctr #(
            .LOW_VAL (field_low(i))
        ) u_ctr (
            .clk    (clk),
            .rst    (rst),
            .inc    (finc[i]),
            .top    (ftop[i]),
            .wr     (fwr[i]),
            .wr_val (wr_data & field_mask(i)),
            .val    (fval[i]),
            .full   (full[i])
        );
    end

    assign year_wrap = finc[F_YEAR] & full[F_YEAR] & ~fwr[F_YEAR];

    always_ff @(posedge clk) begin
        if (rst)
            century <= 1'b0;
        else if (fwr[F_MONTH])
            century <= wr_data[7];
        else if (year_wrap)
            century <= ~century;
    end

    always_comb begin
        rd_data = '0;
        if (rd_sel < SEL_W'(NUM_FIELDS))
            rd_data = fval[rd_sel];
        if (rd_sel == F_SEC)
            rd_data[7] = lv_flag;
        if (rd_sel == F_MONTH)
            rd_data[7] = century;
    end
endmodule

// File: rtl/bcd_calendar_checker.sv
module bcd_calendar_checker (
    input logic       clk,
    input logic       rst,
    input logic       halt,
    input logic       wr_en,
    input logic [2:0] wr_sel,
    input logic       lv_detect,
    input logic [7:0] sec,
    input logic [7:0] hour,
    input logic [7:0] day,
    input logic [7:0] wday,
    input logic [7:0] year,
    input logic       century,
    input logic       lv_flag
);
    p_sec_range_r1: assert property (@(posedge clk) disable iff (rst)
        sec <= 8'h59);

    p_hour_range_r2: assert property (@(posedge clk) disable iff (rst)
        hour <= 8'h23);

    p_day_range_r3: assert property (@(posedge clk) disable iff (rst)
        (day != 8'h00) && (day <= 8'h31));

    p_wday_range_r7: assert property (@(posedge clk) disable iff (rst)
        wday <= 8'h06);

    p_halt_freeze_r8: assert property (@(posedge clk) disable iff (rst)
        (halt && !wr_en) |=> $stable(sec));

    p_century_flip_r6: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> (century == $past(century)) ||
                   ($past(year) == 8'h99 && year == 8'h00));

    p_lv_clear_r10: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_sel == 3'd0 && !lv_detect) |=> !lv_flag);

    p_lv_set_r10: assert property (@(posedge clk) disable iff (rst)
        lv_detect |=> lv_flag);
endmodule

bind bcd_calendar bcd_calendar_checker u_chk (
    .clk       (clk),
    .rst       (rst),
    .halt      (halt),
    .wr_en     (wr_en),
    .wr_sel    (wr_sel),
    .lv_detect (lv_detect),
    .sec       (fval[0]),
    .hour      (fval[2]),
    .day       (fval[3]),
    .wday      (fval[4]),
    .year      (fval[6]),
    .century   (century),
    .lv_flag   (lv_flag)
);

// File: tb/bcd_calendar_bench.sv
module bcd_calendar_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick = 1'b0;
    logic       halt = 1'b0;
    logic       lv_detect = 1'b0;
    logic       wr_en = 1'b0;
    logic [2:0] wr_sel = '0;
    logic [7:0] wr_data = '0;
    logic [2:0] rd_sel = '0;
    logic [7:0] rd_data;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    always #4 clk = ~clk;

    bcd_calendar u_bcd_calendar (
        .clk       (clk),
        .rst       (rst),
        .tick      (tick),
        .halt      (halt),
        .lv_detect (lv_detect),
        .wr_en     (wr_en),
        .wr_sel    (wr_sel),
        .wr_data   (wr_data),
        .rd_sel    (rd_sel),
        .rd_data   (rd_data)
    );

    // req | loaded sec min hour day wday month year | expected after one second
    localparam int NV = 15;
    localparam logic [119:0] VEC [NV] = '{
        120'h01_09_00_00_01_00_01_00_10_00_00_01_00_01_00, // R1 units carry
        120'h01_59_59_05_10_02_03_21_00_00_06_10_02_03_21, // R1 sec+min wrap
        120'h02_59_59_23_14_06_05_22_00_00_00_15_00_05_22, // R2 day wrap, R7 weekday 6->0
        120'h03_59_59_23_30_01_04_22_00_00_00_01_02_05_22, // R3 30-day month
        120'h03_59_59_23_30_03_01_22_00_00_00_31_04_01_22, // R3 day 31 exists
        120'h03_59_59_23_31_04_01_22_00_00_00_01_05_02_22, // R3 31-day month
        120'h03_59_59_23_30_05_09_22_00_00_00_01_06_10_22, // R3 month 09->10
        120'h04_59_59_23_28_02_02_23_00_00_00_01_03_03_23, // R4 plain Feb
        120'h04_59_59_23_28_02_02_24_00_00_00_29_03_02_24, // R4 leap Feb 29
        120'h04_59_59_23_29_03_02_24_00_00_00_01_04_03_24, // R4 leap Feb end
        120'h04_59_59_23_28_00_02_00_00_00_00_29_01_02_00, // R4 year 00 leap
        120'h04_59_59_23_28_01_02_10_00_00_00_01_02_03_10, // R4 year 10 plain
        120'h05_59_59_23_31_05_12_45_00_00_00_01_06_01_46, // R5 year step
        120'h06_59_59_23_31_06_12_99_00_00_00_01_00_81_00, // R6 century 0->1
        120'h06_59_59_23_31_02_92_99_00_00_00_01_03_01_00  // R6 century 1->0
    };

    task automatic check(input string req, input logic [63:0] got, input logic [63:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic write_field(input logic [2:0] sel, input logic [7:0] data);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = data;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic do_tick();
        @(negedge clk);
        tick = 1'b1;
        @(negedge clk);
        tick = 1'b0;
        @(negedge clk);
    endtask

    task automatic read_field(input logic [2:0] sel, output logic [7:0] d);
        rd_sel = sel;
        #1;
        d = rd_data;
    endtask

    task automatic read_all(output logic [55:0] d);
        logic [7:0] b;
        for (int k = 0; k < 7; k++) begin
            read_field(3'(k), b);
            d[55-8*k -: 8] = b;
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin : stim
        logic [55:0]  all;
        logic [7:0]   b;
        logic [119:0] v;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R12 / R10 reset state
        read_all(all);
        check("R12 reset values", 64'(all), 64'h80_00_00_01_00_01_00);

        // R11 seconds write restarts the phase
        write_field(3'd1, 8'h10);
        write_field(3'd0, 8'h20);
        do_tick();
        read_field(3'd0, b);
        check("R11 no step on first tick after sec write", 64'(b), 64'h20);
        do_tick();
        read_field(3'd0, b);
        check("R11 step on second tick", 64'(b), 64'h21);

        // R8 halt freezes
        @(negedge clk); halt = 1'b1;
        do_tick(); do_tick(); do_tick();
        read_all(all);
        check("R8 frozen while halted", 64'(all), 64'h21_10_00_01_00_01_00);

        // R9 half-second restart
        @(negedge clk); halt = 1'b0;
        do_tick();
        read_field(3'd0, b);
        check("R9 first tick after release steps", 64'(b), 64'h22);
        do_tick();
        read_field(3'd0, b);
        check("R9 next tick holds", 64'(b), 64'h22);
        do_tick();
        read_field(3'd0, b);
        check("R9 then every second tick", 64'(b), 64'h23);

        // R11 write beats a carry in the same cycle
        write_field(3'd0, 8'h59);
        do_tick();
        @(negedge clk);
        tick = 1'b1; wr_en = 1'b1; wr_sel = 3'd1; wr_data = 8'h30;
        @(negedge clk);
        tick = 1'b0; wr_en = 1'b0;
        @(negedge clk);
        read_all(all);
        check("R11 minute write wins over carry", 64'(all[55:32]), 64'h00_30_00);

        // R10 low-voltage flag
        @(negedge clk); lv_detect = 1'b1;
        @(negedge clk); lv_detect = 1'b0;
        read_field(3'd0, b);
        check("R10 detect sets bit 7", 64'(b), 64'h80);
        write_field(3'd0, 8'hA5);
        read_field(3'd0, b);
        check("R10 seconds write clears flag", 64'(b), 64'h25);

        // table of one-second steps
        for (int i = 0; i < NV; i++) begin
            v = VEC[i];
            for (int k = 6; k >= 0; k--)
                write_field(3'(k), v[111-8*k -: 8]);
            do_tick();
            do_tick();
            read_all(all);
            check($sformatf("R%0d vector %0d", v[119:112], i), 64'(all), 64'(v[55:0]));
        end

        // R12 reset again after activity
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        read_all(all);
        check("R12 reset after use", 64'(all), 64'h80_00_00_01_00_01_00);

        finish_run();
    end
endmodule